// File: doc/BRIEF.md
# ECC Error Capture and Status Logger

This block sits beside a memory controller's ECC checker and records what it reports. The checker raises a one-cycle single-bit (corrected) or multi-bit (uncorrectable) error event, together with the failing byte address and the 3-bit number of the memory row that was hit. The logger keeps an error address pointer word holding the failing 4 KB page and two sticky kind flags. It also keeps a status word holding, separately for each error kind, a sticky flag and the row of the first such error. Software reads these words through a small register port and clears flags by writing ones to them.

Capture is first-error only. While a flag is set, further errors of that kind leave the associated stored fields untouched. Clearing the flag arms capture again. A command word holds two enable bits. A level-sensitive system-error output is raised while an enabled status flag is set.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, all four register selects read zero and `serr` is low.
- R2: A single-bit event with the pointer single-bit flag clear sets that flag (pointer bit 0), stores `err_addr[31:12]` in pointer bits 31:12, and reads back from the first read after the capturing clock edge. Pointer bits 11:2 always read zero.
- R3: A multi-bit event with the pointer multi-bit flag clear sets pointer bit 1 and stores the page. While the multi-bit flag stays set, a single-bit event never overwrites the page. When both kinds arrive in one cycle, the page comes from that cycle's address and both flags are set.
- R4: While a flag is set and not being cleared, a later event of the same kind changes neither that flag nor the field it guards (the pointer page, or that kind's status row).
- R5: Writing a 1 to pointer bit 0 or bit 1 clears that flag and arms capture again. Writing 0 to a flag, or any value to the page bits, has no effect. Pointer flags and status flags are independent: clearing one leaves the other unchanged. Flags change only through such writes or through a new capture.
- R6: The status word (select 1) holds the single-bit flag in bit 0 and its first row in bits 3:1, and the multi-bit flag in bit 4 and its first row in bits 7:5. Bits 31:8 read zero. A row field keeps its last captured value after its flag is cleared.
- R7: Writing 1 to status bit 0 or bit 4 clears that flag. Writes to the row bits have no effect.
- R8: The command word (select 2) stores bit 1 (multi-bit enable) and bit 0 (single-bit enable). Bits 31:2 read zero and ignore writes. The word changes only when written.
- R9: `serr` is high exactly while (command bit 1 and status multi-bit flag) or (command bit 0 and status single-bit flag). It rises in the cycle after the capturing edge.
- R10: An event arriving in the same cycle as a write that clears its own flag is captured: the flag stays set and the new page or row is stored.
- R11: Register select 0 is the pointer, 1 the status, 2 the command, and 3 reads zero. Nothing changes while `reg_wr` is low, whatever `reg_sel` and `reg_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_in | input | 1 | Single-bit error event, one cycle per error |
| mbe_in | input | 1 | Multi-bit error event, one cycle per error |
| err_addr | input | ADDR_W | Failing byte address for the event |
| err_row | input | ROW_W | Memory row of the event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 pointer, 1 status, 2 command) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the selected register, combinational |
| serr | output | 1 | System-error level output |

## Verification
Two kinds of same-cycle collision matter here. The first is a single-bit and a multi-bit event arriving together, which must give one shared page and both rows. The second is an event arriving in the same cycle as a write-one-to-clear of its own flag, where the event must win. Directed steps drive both collisions with known addresses and rows, and then read all three words back against literal values. A long seeded random phase then mixes event pulses with arbitrary register writes, so that both collisions recur under many flag states. After every cycle, each word and `serr` are compared with a bench model built from the requirements.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

   typedef enum logic [1:0] {
      SEL_PTR  = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CMD  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // error kinds: the index is also the pointer flag bit and the command enable bit
   localparam int KIND_SBE  = 0;
   localparam int KIND_MBE  = 1;
   localparam int NUM_KINDS = 2;

   // status word: kind k owns a flag at k*(ROW_W+1) followed by its row field
   function automatic int stat_flag_pos(input int kind, input int row_w);
      return kind * (row_w + 1);
   endfunction

   function automatic int stat_row_lsb(input int kind, input int row_w);
      return kind * (row_w + 1) + 1;
   endfunction

endpackage

// File: rtl/ecc_log_sticky.sv
// First-event capture slice: one sticky flag plus the data seen with the event.
// An event in the same cycle as a clear is taken (flag stays set).
module ecc_log_sticky #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic         flag,
   output logic [W-1:0] held
);

   logic armed;

   always_comb armed = !flag || clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         held <= '0;
      end else if (ev && armed) begin
         flag <= 1'b1;
         held <= din;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/ecc_log_ptr.sv
// Error address pointer: one shared page field and one flag per error kind.
module ecc_log_ptr
   import ecc_log_pkg::*;
#(
   parameter int PG_W = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_KINDS-1:0] ev,
   input  logic [NUM_KINDS-1:0] clr,
   input  logic [PG_W-1:0]      page_in,
   output logic [NUM_KINDS-1:0] flags,
   output logic [PG_W-1:0]      page
);

   logic [NUM_KINDS-1:0] take;
   logic [NUM_KINDS-1:0] keep;
   logic                 page_load;

   always_comb begin
      for (int k = 0; k < NUM_KINDS; k++) begin
         take[k] = ev[k] && (!flags[k] || clr[k]);
         keep[k] = flags[k] && !clr[k];
      end
      // a held multi-bit page is never replaced by a single-bit error
      page_load = take[KIND_MBE] || (take[KIND_SBE] && !keep[KIND_MBE]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         page  <= '0;
      end else begin
         flags <= take | keep;
         if (page_load) page <= page_in;
      end
   end

endmodule

// File: rtl/ecc_log_regif.sv
// Register port: clear strobes, command word and read multiplexer.
module ecc_log_regif
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int ROW_W      = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic [1:0]                      reg_sel,
   input  logic [ADDR_W-1:0]               reg_wdata,
   input  logic [NUM_KINDS-1:0]            ptr_flags,
   input  logic [ADDR_W-PAGE_SHIFT-1:0]    ptr_page,
   input  logic [NUM_KINDS-1:0]            st_flag,
   input  logic [NUM_KINDS-1:0][ROW_W-1:0] st_row,
   output logic [NUM_KINDS-1:0]            ptr_clr,
   output logic [NUM_KINDS-1:0]            st_clr,
   output logic [NUM_KINDS-1:0]            cmd_en,
   output logic [ADDR_W-1:0]               reg_rdata
);

   reg_sel_e sel;
   logic     cmd_we;
   logic     unused_wbits;

   always_comb begin
      sel    = reg_sel_e'(reg_sel);
      cmd_we = reg_wr && (sel == SEL_CMD);
      for (int k = 0; k < NUM_KINDS; k++) begin
         ptr_clr[k] = reg_wr && (sel == SEL_PTR)  && reg_wdata[k];
         st_clr[k]  = reg_wr && (sel == SEL_STAT) && reg_wdata[stat_flag_pos(k, ROW_W)];
      end
   end

   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)      cmd_en <= '0;
      else if (cmd_we) cmd_en <= reg_wdata[NUM_KINDS-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_PTR: begin
            reg_rdata[ADDR_W-1:PAGE_SHIFT] = ptr_page;
            reg_rdata[NUM_KINDS-1:0]       = ptr_flags;
         end
         SEL_STAT: begin
            for (int k = 0; k < NUM_KINDS; k++) begin
               reg_rdata[stat_flag_pos(k, ROW_W)]         = st_flag[k];
               reg_rdata[stat_row_lsb(k, ROW_W) +: ROW_W] = st_row[k];
            end
         end
         SEL_CMD:  reg_rdata[NUM_KINDS-1:0] = cmd_en;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int ROW_W      = 3,
   parameter int STAT_W     = 16,
   parameter int CMD_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sbe_in,
   input  logic              mbe_in,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [ROW_W-1:0]  err_row,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              serr
);

   localparam int PG_W      = ADDR_W - PAGE_SHIFT;
   localparam int STAT_USED = NUM_KINDS * (ROW_W + 1);

   // elaboration-time parameter checks
   if (PAGE_SHIFT < NUM_KINDS || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
      $error("ecc_err_logger: PAGE_SHIFT must leave room for flags and a page");
   end
   if (STAT_W < STAT_USED || STAT_W > ADDR_W) begin : g_bad_stat
      $error("ecc_err_logger: STAT_W cannot hold both row fields");
   end
   if (CMD_W < NUM_KINDS || CMD_W > ADDR_W) begin : g_bad_cmd
      $error("ecc_err_logger: CMD_W too small for the enable bits");
   end

   logic [NUM_KINDS-1:0]            ev;
   logic [NUM_KINDS-1:0]            ptr_clr;
   logic [NUM_KINDS-1:0]            st_clr;
   logic [NUM_KINDS-1:0]            ptr_flags;
   logic [PG_W-1:0]                 ptr_page_q;
   logic [NUM_KINDS-1:0]            st_flag;
   logic [NUM_KINDS-1:0][ROW_W-1:0] st_row;
   logic [NUM_KINDS-1:0]            cmd_en;
   logic                            unused_addr_lo;

   always_comb begin
      ev[KIND_SBE] = sbe_in;
      ev[KIND_MBE] = mbe_in;
   end

   assign unused_addr_lo = ^err_addr[PAGE_SHIFT-1:0];

   ecc_log_ptr #(.PG_W(PG_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .clr     (ptr_clr),
      .page_in (err_addr[ADDR_W-1:PAGE_SHIFT]),
      .flags   (ptr_flags),
      .page    (ptr_page_q)
   );

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_stat
      ecc_log_sticky #(.W(ROW_W)) u_slice (
         .clk   (clk),
         .rst_n (rst_n),
         .ev    (ev[k]),
         .clr   (st_clr[k]),
         .din   (err_row),
         .flag  (st_flag[k]),
         .held  (st_row[k])
      );
   end

   ecc_log_regif #(
      .ADDR_W     (ADDR_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .ROW_W      (ROW_W)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .ptr_flags (ptr_flags),
      .ptr_page  (ptr_page_q),
      .st_flag   (st_flag),
      .st_row    (st_row),
      .ptr_clr   (ptr_clr),
      .st_clr    (st_clr),
      .cmd_en    (cmd_en),
      .reg_rdata (reg_rdata)
   );

   always_comb serr = |(cmd_en & st_flag);

endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
   parameter int PG_W = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sbe_in,
   input logic            mbe_in,
   input logic [PG_W-1:0] err_page,
   input logic            reg_wr,
   input logic            serr,
   input logic [1:0]      ptr_flags,
   input logic [PG_W-1:0] ptr_page,
   input logic [1:0]      st_flag,
   input logic [1:0]      cmd_en
);

   assert_set_on_sbe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sbe_in && !reg_wr) |=> (ptr_flags[0] && st_flag[0]));

   assert_rise_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_flag[1]) |-> $past(mbe_in));

   assert_mbe_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mbe_in && !ptr_flags[1] && !reg_wr) |=> (ptr_page == $past(err_page)));

   assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_flags[1] && !reg_wr) |=> $stable(ptr_page));

   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_flags[0] && !reg_wr) |=> ptr_flags[0]);

   assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(cmd_en));

   assert_mbe_raises_serr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mbe_in && cmd_en[1] && !reg_wr) |=> serr);

   assert_quiet_serr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_flag == 2'b00) |-> !serr);

endmodule

bind ecc_err_logger ecc_err_logger_chk #(.PG_W(ADDR_W - PAGE_SHIFT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sbe_in    (sbe_in),
   .mbe_in    (mbe_in),
   .err_page  (err_addr[ADDR_W-1:PAGE_SHIFT]),
   .reg_wr    (reg_wr),
   .serr      (serr),
   .ptr_flags (ptr_flags),
   .ptr_page  (ptr_page_q),
   .st_flag   (st_flag),
   .cmd_en    (cmd_en)
);

// File: tb/tb_ecc_err_logger.sv
module tb_ecc_err_logger;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sbe_in, mbe_in;
   logic [31:0] err_addr;
   logic [2:0]  err_row;
   logic        reg_wr;
   logic [1:0]  reg_sel;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        serr;

   int n_checks = 0;
   int n_errors = 0;

   // bench model of the register contents
   bit        m_psbe, m_pmbe;
   bit [19:0] m_page;
   bit [1:0]  m_sf;
   bit [2:0]  m_row [2];
   bit [1:0]  m_cmd;

   always #5 clk = ~clk;

   ecc_err_logger dut (
      .clk(clk), .rst_n(rst_n), .sbe_in(sbe_in), .mbe_in(mbe_in),
      .err_addr(err_addr), .err_row(err_row), .reg_wr(reg_wr),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .serr(serr)
   );

   function automatic logic [31:0] exp_reg(input int s);
      case (s)
         0: return {m_page, 10'b0, m_pmbe, m_psbe};
         1: return {24'b0, m_row[1], m_sf[1], m_row[0], m_sf[0]};
         2: return {30'b0, m_cmd};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_serr();
      return (m_cmd[1] && m_sf[1]) || (m_cmd[0] && m_sf[0]);
   endfunction

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic idle();
      sbe_in = 0; mbe_in = 0; err_addr = '0; err_row = '0;
      reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic model_reset();
      m_psbe = 0; m_pmbe = 0; m_page = '0; m_sf = '0;
      m_row[0] = '0; m_row[1] = '0; m_cmd = '0;
   endtask

   // one clock: drive, let the edge capture, update the model, go idle
   task automatic step(input bit s, input bit m, input logic [31:0] a, input logic [2:0] r,
                       input bit w, input logic [1:0] sel, input logic [31:0] wd);
      bit clr_ps, clr_pm, keep_m, take_s, take_m;
      bit [1:0] sclr, sev;
      sbe_in = s; mbe_in = m; err_addr = a; err_row = r;
      reg_wr = w; reg_sel = sel; reg_wdata = wd;
      @(posedge clk);
      clr_ps  = w && sel == 2'd0 && wd[0];
      clr_pm  = w && sel == 2'd0 && wd[1];
      sclr[0] = w && sel == 2'd1 && wd[0];
      sclr[1] = w && sel == 2'd1 && wd[4];
      sev     = {m, s};
      take_m  = m && (!m_pmbe || clr_pm);
      take_s  = s && (!m_psbe || clr_ps);
      keep_m  = m_pmbe && !clr_pm;
      if (take_m || (take_s && !keep_m)) m_page = a[31:12];
      m_pmbe = take_m || keep_m;
      m_psbe = take_s || (m_psbe && !clr_ps);
      for (int k = 0; k < 2; k++) begin
         if (sev[k] && (!m_sf[k] || sclr[k])) begin
            m_sf[k] = 1'b1; m_row[k] = r;
         end else if (sclr[k]) m_sf[k] = 1'b0;
      end
      if (w && sel == 2'd2) m_cmd = wd[1:0];
      #1;
      idle();
   endtask

   task automatic check_all(input string tag);
      for (int s = 0; s < 4; s++) begin
         reg_sel = 2'(s);
         #1;
         chk(reg_rdata, exp_reg(s), $sformatf("%s sel%0d R11", tag, s));
      end
      chk({31'b0, serr}, {31'b0, exp_serr()}, {tag, " serr R9"});
   endtask

   task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
      reg_sel = s;
      #1;
      chk(reg_rdata, exp, tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; reg_sel = 0; idle(); model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      check_all("R1 reset");

      // R2: first single-bit error
      step(1, 0, 32'h1234_5ABC, 3'd5, 0, 0, 0);
      rd(0, 32'h1234_5001, "R2 pointer after sbe");
      rd(1, 32'h0000_000B, "R6 status after sbe");
      // R4: second single-bit error ignored
      step(1, 0, 32'hAAAA_A000, 3'd2, 0, 0, 0);
      rd(0, 32'h1234_5001, "R4 pointer held");
      rd(1, 32'h0000_000B, "R4 status row held");
      // R3: multi-bit error
      step(0, 1, 32'h8765_4321, 3'd6, 0, 0, 0);
      rd(0, 32'h8765_4003, "R3 pointer after mbe");
      rd(1, 32'h0000_00DB, "R6 status both kinds");
      // R5: writes of zeros to flags and ones to page bits do nothing
      step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFFC);
      rd(0, 32'h8765_4003, "R5 write zero ignored");
      // R5: clear single-bit pointer flag only
      step(0, 0, 0, 0, 1, 0, 32'h0000_0001);
      rd(0, 32'h8765_4002, "R5 w1c pointer sbe");
      rd(1, 32'h0000_00DB, "R5 status independent");
      // R3: re-armed sbe does not replace multi-bit page
      step(1, 0, 32'h1111_1000, 3'd1, 0, 0, 0);
      rd(0, 32'h8765_4003, "R3 mbe page kept");
      // R7: row bits read-only, then clear both status flags
      step(0, 0, 0, 0, 1, 1, 32'h0000_00EE);
      rd(1, 32'h0000_00DB, "R7 row write ignored");
      step(0, 0, 0, 0, 1, 1, 32'h0000_0011);
      rd(1, 32'h0000_00CA, "R7 w1c status rows kept");
      // R8: command word
      step(0, 0, 0, 0, 1, 2, 32'hFFFF_FFFF);
      rd(2, 32'h0000_0003, "R8 command reserved bits");
      chk({31'b0, serr}, 32'd0, "R9 serr low with flags clear");
      step(1, 0, 32'h0000_0000, 3'd3, 0, 0, 0);
      rd(1, 32'h0000_00C7, "R6 status new sbe row");
      chk({31'b0, serr}, 32'd1, "R9 serr on enabled sbe");
      step(0, 0, 0, 0, 1, 2, 32'h0000_0002);
      chk({31'b0, serr}, 32'd0, "R9 serr sbe disabled");
      step(0, 1, 32'h0000_0000, 3'd4, 0, 0, 0);
      chk({31'b0, serr}, 32'd1, "R9 serr on enabled mbe");
      rd(1, 32'h0000_0097, "R6 status new mbe row");
      // R10: error meets clear of its own flag
      step(0, 1, 32'h0F0F_0000, 3'd0, 1, 0, 32'h0000_0003);
      rd(0, 32'h0F0F_0002, "R10 pointer event beats clear");
      rd(1, 32'h0000_0097, "R4 status mbe held");
      step(0, 1, 32'h0000_0000, 3'd7, 1, 1, 32'h0000_0010);
      rd(1, 32'h0000_00F7, "R10 status event beats clear");
      // R3: both kinds in one cycle from clean flags
      step(0, 0, 0, 0, 1, 0, 32'h0000_0003);
      step(0, 0, 0, 0, 1, 1, 32'h0000_0011);
      rd(0, 32'h0F0F_0000, "R5 pointer cleared");
      rd(1, 32'h0000_00E6, "R7 status cleared");
      step(1, 1, 32'h2468_0FFF, 3'd2, 0, 0, 0);
      rd(0, 32'h2468_0003, "R3 both kinds pointer");
      rd(1, 32'h0000_0055, "R3 both kinds status");
      // R11: no write when strobe low
      step(0, 0, 0, 0, 0, 2, 32'hFFFF_FFFF);
      rd(2, 32'h0000_0002, "R11 no write without strobe");
      check_all("R1 R2 directed tail");

      // random phase, model compared every cycle
      for (int i = 0; i < 600; i++) begin
         bit s, m, w;
         logic [1:0]  sel;
         logic [31:0] a, wd;
         s   = ($urandom % 3) == 0;
         m   = ($urandom % 4) == 0;
         w   = ($urandom % 3) == 0;
         sel = 2'($urandom % 4);
         a   = $urandom;
         wd  = $urandom;
         step(s, m, a, 3'($urandom % 8), w, sel, wd);
         check_all("R2 R3 R4 R5 R6 R7 R8 R10 random");
      end

      summary();
      $finish;
   end

endmodule